// File: doc/BRIEF.md
# Process-Tagged Translation Buffer with Page-Table Refill

This block turns virtual addresses into physical addresses. It keeps a small, fully associative set of recently used translations. Each stored translation is tagged with both the virtual page number and the process identifier that owns it, so translations for several processes can be held at the same time without a flush on every context switch. A lookup whose page number and process identifier match a valid stored translation is answered in the next cycle, with no memory traffic.

When no stored translation matches, the block reads the page-table entry for that page from memory. The read address is the configured table base plus eight bytes per page. If the fetched entry is valid, the block answers the request with the fetched frame and stores the translation in a slot chosen by a round-robin pointer, which may displace an older translation. If the fetched entry is invalid, the block answers with a page fault and stores nothing. Only one miss is handled at a time. New requests are held off until the answer for the miss has been given. A flush input clears every stored translation in one cycle.

Addresses are 32 bits with a 4 KiB page: a 20-bit page number and a 12-bit offset. A physical address is the 20-bit frame number joined to the unchanged offset. Page-table entries are 64 bits wide.

Top module: `tlb_top`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` is 0, `mem_req` is 0 and no translation is stored, so the first lookup of any page misses.
- R2: A lookup accepted when `req_valid` and `req_ready` are both 1 hits only when a stored translation is valid and its page number (`req_vaddr[31:12]`) and process tag both equal the request's (`cfg_pid`). A hit gives `resp_valid`=1 in the next cycle with `resp_hit`=1, `resp_fault`=0, `resp_paddr` = {frame, `req_vaddr[11:0]`}, and no memory read. At most one stored translation ever matches.
- R3: On a miss, `mem_req` rises in the cycle after acceptance with `mem_addr` = `cfg_ptbase` + 8 × page number. The request and address are held unchanged until `mem_rvalid` is seen, and exactly one read is made per miss.
- R4: A page-table entry carries the frame number in bits [37:18] and its valid flag in bit 10. All other bits are ignored. In the cycle after `mem_rvalid`, a valid entry gives `resp_valid`=1, `resp_hit`=0, `resp_fault`=0 and `resp_paddr` = {entry frame, saved offset}.
- R5: A valid fetched entry is stored together with the request's page number and process tag, so a later lookup of that page by that process hits.
- R6: The same page number under a different `cfg_pid` does not match, and both translations can be held at once.
- R7: A fetched entry with bit 10 clear gives `resp_fault`=1, `resp_hit`=0 and `resp_paddr`=0, and it is not stored, so a repeat lookup misses and reads memory again.
- R8: Storing uses a round-robin slot pointer that starts at slot 0 after reset and advances by one, wrapping, on each successful store. With ENTRIES slots, the (ENTRIES+1)-th store displaces the first translation stored.
- R9: A one-cycle pulse on `flush` invalidates every stored translation by the next cycle, so later lookups miss.
- R10: From the cycle after a miss is accepted until its response cycle, `req_ready` is 0 and no other response is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ptbase | input | 32 | Byte address of the page table in use |
| cfg_pid | input | 6 | Process identifier of the running process |
| flush | input | 1 | Invalidate all stored translations |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can accept a lookup |
| req_vaddr | input | 32 | Virtual address to translate |
| resp_valid | output | 1 | Response present (one-cycle pulse) |
| resp_hit | output | 1 | Response came from a stored translation |
| resp_fault | output | 1 | Page-table entry was invalid |
| resp_paddr | output | 32 | Translated physical address |
| mem_req | output | 1 | Page-table read request, held until data returns |
| mem_addr | output | 32 | Byte address of the page-table entry |
| mem_rvalid | input | 1 | Page-table data present |
| mem_rdata | input | 64 | Page-table entry read from memory |

## Verification
The assertions check on every cycle that at most one stored translation matches a lookup, and that `req_ready` stays low while a table read is open. They also check that the read address holds steady until data returns, that a fault response never claims a hit, that a flush leaves no valid slot, and that each store sets the slot it targeted and moves the pointer by one. Only the bench's scenarios can show the values involved: correct frames and offsets, coexisting tags for two processes under different table bases, and a fault that is not cached and so is fetched again. They also show which translation is displaced once every slot is full, and misses after a flush.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;
  localparam int VA_W  = 32;
  localparam int OFF_W = 12;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PID_W = 6;
  localparam int PFN_W = 20;
  localparam int PA_W  = PFN_W + OFF_W;
  localparam int MA_W  = 32;
  localparam int PTE_W = 64;
  localparam int PTE_BYTES_LG = 3;
  localparam int PTE_VLD_BIT = 10;
  localparam int PTE_PFN_LSB = 18;

  typedef struct packed {
    logic             v;
    logic [VPN_W-1:0] vpn;
    logic [PID_W-1:0] pid;
    logic [PFN_W-1:0] pfn;
  } tlb_ent_t;

  function automatic logic [MA_W-1:0] pte_addr(input logic [MA_W-1:0] base,
                                               input logic [VPN_W-1:0] vpn);
    return base + MA_W'({vpn, {PTE_BYTES_LG{1'b0}}});
  endfunction

  function automatic logic [PA_W-1:0] join_pa(input logic [PFN_W-1:0] pfn,
                                              input logic [OFF_W-1:0] off);
    return {pfn, off};
  endfunction

  function automatic logic [PFN_W-1:0] pte_pfn(input logic [PTE_W-1:0] pte);
    return pte[PTE_PFN_LSB +: PFN_W];
  endfunction

  function automatic logic pte_ok(input logic [PTE_W-1:0] pte);
    return pte[PTE_VLD_BIT];
  endfunction
endpackage

// File: rtl/tlb_cam.sv
`timescale 1ns/1ps
module tlb_cam
  import tlb_pkg::*;
#(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [PID_W-1:0] lk_pid,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PID_W-1:0] wr_pid,
  input  logic [PFN_W-1:0] wr_pfn,
  output logic [N-1:0]     hit_vec,
  output logic [N-1:0]     valid_vec,
  output logic [PFN_W-1:0] hit_pfn
);
  tlb_ent_t ent [N];

  for (genvar g = 0; g < N; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent[g] <= '0;
      end else if (flush) begin
        ent[g].v <= 1'b0;
      end else if (wr_en && (wr_idx == IW'(g))) begin
        ent[g] <= '{v: 1'b1, vpn: wr_vpn, pid: wr_pid, pfn: wr_pfn};
      end
    end
    assign hit_vec[g]   = ent[g].v && (ent[g].vpn == lk_vpn) && (ent[g].pid == lk_pid);
    assign valid_vec[g] = ent[g].v;
  end

  always_comb begin
    hit_pfn = '0;
    for (int i = 0; i < N; i++) begin
      hit_pfn = hit_pfn | (ent[i].pfn & {PFN_W{hit_vec[i]}});
    end
  end
endmodule

// File: rtl/tlb_victim.sv
`timescale 1ns/1ps
module tlb_victim #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [IW-1:0] idx
);
  always_ff @(posedge clk) begin
    if (!rst_n)        idx <= '0;
    else if (adv)      idx <= (idx == IW'(N - 1)) ? '0 : idx + 1'b1;
  end
endmodule

// File: rtl/tlb_top.sv
`timescale 1ns/1ps
module tlb_top
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MA_W-1:0]  cfg_ptbase,
  input  logic [PID_W-1:0] cfg_pid,
  input  logic             flush,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             resp_valid,
  output logic             resp_hit,
  output logic             resp_fault,
  output logic [PA_W-1:0]  resp_paddr,
  output logic             mem_req,
  output logic [MA_W-1:0]  mem_addr,
  input  logic             mem_rvalid,
  input  logic [PTE_W-1:0] mem_rdata
);
  typedef enum logic {ST_IDLE, ST_FETCH} st_t;
  st_t st;

  logic [VPN_W-1:0]   pend_vpn;
  logic [OFF_W-1:0]   pend_off;
  logic [PID_W-1:0]   pend_pid;
  logic [ENTRIES-1:0] hit_vec;
  logic [ENTRIES-1:0] valid_vec;
  logic [PFN_W-1:0]   hit_pfn;
  logic [IW-1:0]      victim;

  // named internal events
  logic [VPN_W-1:0] lk_vpn;
  logic [OFF_W-1:0] lk_off;
  logic             accept, lk_hit, fetch_done, fill_ok, fill_fire;

  assign lk_vpn     = req_vaddr[VA_W-1:OFF_W];
  assign lk_off     = req_vaddr[OFF_W-1:0];
  assign req_ready  = (st == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign lk_hit     = |hit_vec;
  assign mem_req    = (st == ST_FETCH);
  assign fetch_done = mem_req && mem_rvalid;
  assign fill_ok    = fetch_done && pte_ok(mem_rdata);
  assign fill_fire  = fill_ok && !flush;

  tlb_cam #(.N(ENTRIES)) u_cam (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_vpn(lk_vpn), .lk_pid(cfg_pid),
    .wr_en(fill_fire), .wr_idx(victim),
    .wr_vpn(pend_vpn), .wr_pid(pend_pid), .wr_pfn(pte_pfn(mem_rdata)),
    .hit_vec(hit_vec), .valid_vec(valid_vec), .hit_pfn(hit_pfn)
  );

  tlb_victim #(.N(ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_n), .adv(fill_fire), .idx(victim)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      pend_vpn   <= '0;
      pend_off   <= '0;
      pend_pid   <= '0;
      mem_addr   <= '0;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_fault <= 1'b0;
      resp_paddr <= '0;
    end else begin
      resp_valid <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (accept && lk_hit) begin
            resp_valid <= 1'b1;
            resp_hit   <= 1'b1;
            resp_fault <= 1'b0;
            resp_paddr <= join_pa(hit_pfn, lk_off);
          end else if (accept) begin
            st       <= ST_FETCH;
            pend_vpn <= lk_vpn;
            pend_off <= lk_off;
            pend_pid <= cfg_pid;
            mem_addr <= pte_addr(cfg_ptbase, lk_vpn);
          end
        end
        ST_FETCH: begin
          if (mem_rvalid) begin
            st         <= ST_IDLE;
            resp_valid <= 1'b1;
            resp_hit   <= 1'b0;
            resp_fault <= !fill_ok;
            resp_paddr <= fill_ok ? join_pa(pte_pfn(mem_rdata), pend_off) : '0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tlb_top_chk.sv
`timescale 1ns/1ps
module tlb_top_chk #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          req_ready,
  input logic          mem_req,
  input logic [31:0]   mem_addr,
  input logic          mem_rvalid,
  input logic          resp_valid,
  input logic          resp_hit,
  input logic          resp_fault,
  input logic [N-1:0]  hit_vec,
  input logic [N-1:0]  valid_vec,
  input logic [IW-1:0] victim,
  input logic          fill_fire
);
  a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  a_r10_stall_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);

  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

  a_r7_fault_not_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault) |-> !resp_hit);

  a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_vec == '0));

  a_r5_fill_sets_slot: assert property (@(posedge clk) disable iff (!rst_n)
    fill_fire |=> valid_vec[$past(victim)]);

  a_r8_pointer_step: assert property (@(posedge clk) disable iff (!rst_n)
    fill_fire |=> (victim == (($past(victim) == IW'(N - 1)) ? '0 : $past(victim) + 1'b1)));
endmodule

bind tlb_top tlb_top_chk #(.N(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .req_ready(req_ready),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
  .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_fault(resp_fault),
  .hit_vec(hit_vec), .valid_vec(valid_vec), .victim(victim), .fill_fire(fill_fire)
);

// File: tb/tb_tlb_top.sv
`timescale 1ns/1ps
module tb_tlb_top;
  localparam int N = 8;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [31:0] cfg_ptbase;
  logic [5:0]  cfg_pid;
  logic        flush, req_valid, req_ready;
  logic [31:0] req_vaddr;
  logic        resp_valid, resp_hit, resp_fault;
  logic [31:0] resp_paddr;
  logic        mem_req, mem_rvalid;
  logic [31:0] mem_addr;
  logic [63:0] mem_rdata;

  tlb_top #(.ENTRIES(N)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_ptbase(cfg_ptbase), .cfg_pid(cfg_pid), .flush(flush),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_fault(resp_fault),
    .resp_paddr(resp_paddr), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  initial forever #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0, mem_reads = 0;
  bit done = 0, pending = 0;
  logic [31:0] last_maddr = '0;
  bit [63:0] ptmem [bit [31:0]];

  // behavioural reference: translation slots and round-robin pointer
  bit        mv   [N];
  bit [19:0] mvpn [N];
  bit [5:0]  mpid [N];
  bit [19:0] mpfn [N];
  int        mrr = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic bit [63:0] mk_pte(bit [19:0] vpn, bit [5:0] pid, bit [19:0] pfn, bit v);
    return {vpn, pid, pfn, 7'b0, v, 10'b0};
  endfunction

  // page-table memory: two cycles of latency, one data beat
  initial begin
    mem_rvalid = 0;
    mem_rdata  = '0;
    forever begin
      @(negedge clk);
      if (mem_req && !mem_rvalid) begin
        bit [31:0] a;
        a = mem_addr;
        mem_reads++;
        last_maddr = a;
        repeat (2) @(negedge clk);
        mem_rdata  = ptmem.exists(a) ? ptmem[a] : 64'h0;
        mem_rvalid = 1;
        @(negedge clk);
        mem_rvalid = 0;
      end
    end
  end

  // every-clock comparison: the model allows responses and reads only during a lookup (R10)
  initial forever begin
    @(negedge clk);
    if (rst_n && resp_valid && !pending) chk(0, "R10 response outside a lookup", 1, 0);
    if (rst_n && mem_req && !pending)    chk(0, "R3 read outside a lookup", 1, 0);
  end

  task automatic lookup(input bit [31:0] va, input string tag);
    bit [19:0] vpn = va[31:12];
    bit        ehit = 0;
    bit [19:0] epfn = '0;
    bit [31:0] ea, epa;
    bit [63:0] pte;
    bit        efault = 0;
    int        reads0, w;
    for (int i = 0; i < N; i++)
      if (mv[i] && mvpn[i] == vpn && mpid[i] == cfg_pid) begin ehit = 1; epfn = mpfn[i]; end
    ea  = cfg_ptbase + {vpn, 3'b000};
    pte = ptmem.exists(ea) ? ptmem[ea] : 64'h0;
    if (!ehit) begin
      efault = !pte[10];
      epfn   = pte[37:18];
    end
    epa = efault ? 32'h0 : {epfn, va[11:0]};
    reads0 = mem_reads;
    pending = 1;
    @(negedge clk);
    req_valid = 1; req_vaddr = va;
    @(negedge clk);
    req_valid = 0;
    if (!ehit) chk(req_ready == 0, {tag, " R10 ready low during miss"}, req_ready, 0);
    w = 0;
    while (!resp_valid && w < 200) begin @(negedge clk); w++; end
    chk(resp_valid == 1, {tag, " response seen"}, resp_valid, 1);
    chk(resp_hit == ehit, {tag, " hit flag"}, resp_hit, ehit);
    chk(resp_fault == efault, {tag, " fault flag"}, resp_fault, efault);
    chk(resp_paddr == epa, {tag, " physical address"}, resp_paddr, epa);
    chk(mem_reads - reads0 == (ehit ? 0 : 1), {tag, " R3 table reads"}, mem_reads - reads0, ehit ? 0 : 1);
    if (!ehit) chk(last_maddr == ea, {tag, " R3 table address"}, last_maddr, ea);
    if (!ehit && !efault) begin
      mv[mrr] = 1; mvpn[mrr] = vpn; mpid[mrr] = cfg_pid; mpfn[mrr] = epfn;
      mrr = (mrr + 1) % N;
    end
    @(negedge clk);
    pending = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  localparam bit [31:0] BASE_A = 32'h0001_0000;
  localparam bit [31:0] BASE_B = 32'h0002_0000;

  initial begin
    flush = 0; req_valid = 0; req_vaddr = '0;
    cfg_pid = 6'd1; cfg_ptbase = BASE_A;
    for (int i = 0; i < N; i++) mv[i] = 0;
    ptmem[BASE_A + (32'h10 << 3)] = mk_pte(20'h10, 6'd1, 20'h80010, 1);
    for (int v = 'h20; v < 'h28; v++)
      ptmem[BASE_A + (v << 3)] = mk_pte(20'(v), 6'd1, 20'h80000 | 20'(v), 1);
    ptmem[BASE_B + (32'h10 << 3)] = mk_pte(20'h10, 6'd2, 20'h44010, 1);
    ptmem[BASE_A + (32'hbad << 3)] = mk_pte(20'hbad, 6'd1, 20'h12345, 0);

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1, "R1 ready after reset", req_ready, 1);
    chk(resp_valid == 0, "R1 no response after reset", resp_valid, 0);
    chk(mem_req == 0, "R1 no read after reset", mem_req, 0);

    lookup(32'h0001_0123, "R1 R4 first lookup misses and refills");
    lookup(32'h0001_0123, "R2 R5 repeat lookup hits");
    lookup(32'h0001_0FFE, "R2 other offset same page");

    cfg_pid = 6'd2; cfg_ptbase = BASE_B;
    lookup(32'h0001_0456, "R6 same page other process misses");
    lookup(32'h0001_0457, "R6 second process now hits");
    cfg_pid = 6'd1; cfg_ptbase = BASE_A;
    lookup(32'h0001_0789, "R6 first process still hits");

    lookup(32'h00BA_D010, "R7 invalid entry faults");
    lookup(32'h00BA_D020, "R7 fault was not stored");

    for (int v = 'h20; v < 'h27; v++) lookup({20'(v), 12'h040}, "R8 fill slots");
    lookup(32'h0001_0ABC, "R8 oldest translation displaced");
    lookup(32'h0002_0111, "R8 newer translation kept");

    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
    for (int i = 0; i < N; i++) mv[i] = 0;
    lookup(32'h0002_0222, "R9 lookup after flush misses");
    lookup(32'h0002_0333, "R9 refilled after flush");

    finish_run();
  end
endmodule